// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block connects a simple on-chip request port to an external asynchronous static RAM of 512K words by 32 bits. The RAM has one active-low select and one active-low write strobe per byte lane, and a single active-low output enable. The controller takes one read or write at a time through a valid/ready handshake. It drives the word address, the lane selects, the output enable and the write strobes with the timing that the RAM needs. It returns read data as a single-cycle response pulse. The bidirectional data bus is split into an output value, an output enable and an input value; the pad is built outside the block.

All timing limits are parameters in nanoseconds, together with the clock period. Each limit is rounded up to whole cycles, and from these the block derives three counts: the read access length, the address setup before the write strobe, and the write strobe length. A width-mode input lets the same RAM serve as a 32-bit, 16-bit or 8-bit memory. In the narrow modes the low request address bits pick a half-word or byte lane. Write data is copied onto the chosen lane and read data is taken from it.

The controller drives its data outputs only while a write strobe is active, and it keeps the output enable high for the whole of every write. When a write follows straight after a read, it adds one extra deselected cycle. With no request waiting, every lane select is high and the RAM sits in standby.

Top module: `sram_ctl`

## Requirements
- R1: Out of reset, and whenever the controller is idle, all four lane selects, the output enable and all four write strobes are high (inactive), the data output enable is low and req_ready is high.
- R2: A read holds the selected lanes' selects low, output enable low and all write strobes high for RD_CYC consecutive cycles. RD_CYC is the largest of ceil(read cycle time), ceil(address access time) and ceil(output-enable access time), each divided by the clock period and never below 1 (5 cycles at 4 ns). Data is sampled at the clock edge that ends the last of those cycles, and rsp_valid is high for exactly the one following cycle.
- R3: A write first spends AS_CYC cycles with the lane selects low and the strobes high. AS_CYC is ceil(address setup / period), at least 1. It then drives the strobes of the written lanes low for WP_CYC cycles. WP_CYC is the largest of ceil(write pulse), ceil(data setup), and ceil(write cycle), ceil(select-to-end) and ceil(address-to-end) each less AS_CYC (4 cycles at 4 ns). Address and data stay unchanged while a strobe is low, and a strobe only falls on a lane whose select is already low.
- R4: mem_dq_oe is high only in cycles in which at least one write strobe is low. The output enable is high for the whole of a write.
- R5: When a write is accepted within one cycle of the end of a read, at least two cycles with all selects high separate the read's last select-low cycle from the write's first one. Otherwise consecutive accesses are separated by one idle cycle.
- R6: Width mode 0 (32-bit), and mode 3 which acts the same, use mem_addr = req_addr[18:0]. A read selects all four lanes and returns the full word. A write selects lane i (data bits 8i+7..8i) exactly when req_mask[i] is 1.
- R7: Width mode 1 (16-bit) uses mem_addr = req_addr[19:1]. req_addr[0]=1 picks lanes 3..2 and req_addr[0]=0 picks lanes 1..0. req_wdata[15:0] is copied to both halves, req_mask[1:0] gates the low and high lane of the chosen half, and a read returns the chosen half-word zero-extended.
- R8: Width mode 2 (8-bit) uses mem_addr = req_addr[20:2], and req_addr[1:0] picks one lane. req_wdata[7:0] is copied to all lanes, a write happens only when req_mask[0] is 1, and a read returns the chosen byte zero-extended. A write with req_mask[0]=0 leaves memory unchanged.
- R9: A request is accepted on a clock edge where req_valid and req_ready are both high. req_ready is low from the cycle after acceptance until the access has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wmode | input | 2 | Width mode: 0/3 32-bit, 1 16-bit, 2 8-bit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 21 | Request address in units of the current width |
| req_wdata | input | 32 | Write data |
| req_mask | input | 4 | Byte mask for writes |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 32 | Read data |
| mem_addr | output | 19 | RAM word address |
| mem_cs_n | output | 4 | Lane selects, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 4 | Lane write strobes, active low |
| mem_dq_o | output | 32 | Data bus value driven to RAM |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 32 | Data bus value from RAM |

## Verification
The assertions check on every cycle that nothing is active while the controller is idle, that output enable and write strobes are never low together, and that the data bus is driven only under a strobe. They also check that a strobe falls only after a setup cycle on already-selected lanes, that address and data hold steady under the strobe, that a response follows a read, and that a write never comes straight after a read without the extra cycle. Only the bench's scenarios can show the exact pulse lengths, the word addresses and lane choices in each width mode, and that data written in one width reads back correctly in another. The same goes for masked writes that must leave bytes untouched.

// File: rtl/sram_ctl_pkg.sv
// Shared types and constant helpers for the static RAM controller.
// Assumes a RAM with four 8-bit lanes.
package sram_ctl_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 4;
    localparam int DATA_W = LANE_W * LANES;
    localparam int TAG_W  = 4;

    // Width mode as seen on cfg_wmode
    typedef enum logic [1:0] {
        WM_32  = 2'd0,
        WM_16  = 2'd1,
        WM_8   = 2'd2,
        WM_32B = 2'd3
    } wmode_e;

    // Access sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_SETUP,
        ST_WRITE,
        ST_READ
    } seq_st_e;

    // Nanoseconds to whole cycles, rounded up, never below one
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    // Larger of two integers
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_lanes.sv
// Request steering: maps a request address onto a RAM word address and
// a lane set for the current width mode, and copies write data onto lanes.
// Assumes four 8-bit lanes; purely combinational.
module sram_ctl_lanes
    import sram_ctl_pkg::*;
#(
    parameter int WADDR_W = 19
) (
    input  logic [1:0]          mode,
    input  logic [WADDR_W+1:0]  addr,
    input  logic                write,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [LANES-1:0]    mask,
    output logic [WADDR_W-1:0]  word_addr,
    output logic [LANES-1:0]    lanes,
    output logic [DATA_W-1:0]   lane_wdata
);

    logic [LANES-1:0] rd_lane;
    logic [LANES-1:0] wr_lane;

    // Pick the word address bits for the width mode
    always_comb begin
        case (mode)
            WM_16:   word_addr = addr[WADDR_W:1];
            WM_8:    word_addr = addr[WADDR_W+1:2];
            default: word_addr = addr[WADDR_W-1:0];
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic       HI_HALF = (i >= LANES / 2);
        localparam logic [1:0] IDX     = 2'(i);
        localparam int         HALF_I  = i % (LANES / 2);

        logic hit16;
        logic hit8;

        assign hit16 = (addr[0] == HI_HALF);
        assign hit8  = (addr[1:0] == IDX);

        // Lane taking part in a read
        assign rd_lane[i] = (mode == WM_16) ? hit16 :
                            (mode == WM_8)  ? hit8  : 1'b1;

        // Lane written, gated by the byte mask
        assign wr_lane[i] = (mode == WM_16) ? (hit16 & mask[HALF_I]) :
                            (mode == WM_8)  ? (hit8 & mask[0])       : mask[i];

        // Data copied onto this lane
        assign lane_wdata[i*LANE_W +: LANE_W] =
            (mode == WM_16) ? wdata[HALF_I*LANE_W +: LANE_W] :
            (mode == WM_8)  ? wdata[LANE_W-1:0]              :
                              wdata[i*LANE_W +: LANE_W];
    end

    assign lanes = write ? wr_lane : rd_lane;

endmodule

// File: rtl/sram_ctl_rdext.sv
// Read data extraction: picks the half-word or byte chosen at request
// time out of the raw RAM word and zero-extends it. Combinational.
module sram_ctl_rdext
    import sram_ctl_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic [1:0]        lo,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] rdata
);

    // Select the lane(s) for the width mode
    always_comb begin
        case (mode)
            WM_16:   rdata = lo[0] ? {16'h0, raw[31:16]} : {16'h0, raw[15:0]};
            WM_8:    rdata = {24'h0, raw[{lo, 3'b000} +: LANE_W]};
            default: rdata = raw;
        endcase
    end

endmodule

// File: rtl/sram_ctl_seq.sv
// Access sequencer: accepts one request at a time and plays the select,
// output-enable and write-strobe sequence for it, with cycle counts given
// as parameters. All RAM-side outputs come straight from flops.
// Assumes the request steering is already applied to its inputs.
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int WADDR_W = 19,
    parameter int RD_CYC  = 2,
    parameter int AS_CYC  = 1,
    parameter int WP_CYC  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    output logic                req_ready,
    input  logic [WADDR_W-1:0]  map_addr,
    input  logic [LANES-1:0]    map_lanes,
    input  logic [DATA_W-1:0]   map_wdata,
    input  logic [TAG_W-1:0]    map_tag,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_raw,
    output logic [TAG_W-1:0]    rsp_tag,
    output logic [WADDR_W-1:0]  mem_addr,
    output logic [LANES-1:0]    mem_cs_n,
    output logic                mem_oe_n,
    output logic [LANES-1:0]    mem_we_n,
    output logic [DATA_W-1:0]   mem_dq_o,
    output logic                mem_dq_oe,
    input  logic [DATA_W-1:0]   mem_dq_i
);

    localparam int MAXC  = imax(imax(RD_CYC, AS_CYC), WP_CYC);
    localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);
    localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] AS_LD = CNT_W'(AS_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);

    seq_st_e              st_q, st_d;
    logic [CNT_W-1:0]     cnt_q, cnt_d;
    logic                 last_rd_q;
    logic [WADDR_W-1:0]   addr_q, addr_nx;
    logic [LANES-1:0]     lanes_q, lanes_nx;
    logic [DATA_W-1:0]    wdata_q, wdata_nx;
    logic [TAG_W-1:0]     tag_q;
    logic                 accept;
    logic                 cnt_zero;
    logic                 rd_done;

    assign req_ready = (st_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign cnt_zero  = (cnt_q == '0);
    assign rd_done   = (st_q == ST_READ) && cnt_zero;

    // Request fields seen by the output stage this cycle
    always_comb begin
        addr_nx  = accept ? map_addr  : addr_q;
        lanes_nx = accept ? map_lanes : lanes_q;
        wdata_nx = accept ? map_wdata : wdata_q;
    end

    // Next state and phase counter
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!req_write) begin
                        st_d  = ST_READ;
                        cnt_d = RD_LD;
                    end else if (last_rd_q) begin
                        st_d  = ST_TURN;
                    end else begin
                        st_d  = ST_SETUP;
                        cnt_d = AS_LD;
                    end
                end
            end
            ST_TURN: begin
                st_d  = ST_SETUP;
                cnt_d = AS_LD;
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    st_d  = ST_WRITE;
                    cnt_d = WP_LD;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_WRITE, ST_READ: begin
                if (cnt_zero) st_d  = ST_IDLE;
                else          cnt_d = cnt_q - 1'b1;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State, counter and latched request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            cnt_q     <= '0;
            last_rd_q <= 1'b0;
            addr_q    <= '0;
            lanes_q   <= '0;
            wdata_q   <= '0;
            tag_q     <= '0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            addr_q  <= addr_nx;
            lanes_q <= lanes_nx;
            wdata_q <= wdata_nx;
            if (accept) tag_q <= map_tag;
            if (rd_done)
                last_rd_q <= 1'b1;
            else if ((st_q == ST_IDLE && !accept) || st_d == ST_SETUP)
                last_rd_q <= 1'b0;
        end
    end

    // RAM-side control outputs, registered from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_dq_o  <= '0;
            mem_cs_n  <= '1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= '1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_addr  <= addr_nx;
            mem_dq_o  <= wdata_nx;
            mem_cs_n  <= '1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= '1;
            mem_dq_oe <= 1'b0;
            case (st_d)
                ST_SETUP: mem_cs_n <= ~lanes_nx;
                ST_WRITE: begin
                    mem_cs_n  <= ~lanes_nx;
                    mem_we_n  <= ~lanes_nx;
                    mem_dq_oe <= |lanes_nx;
                end
                ST_READ: begin
                    mem_cs_n <= ~lanes_nx;
                    mem_oe_n <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Read sample at the end of the access and response strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_raw   <= '0;
            rsp_tag   <= '0;
        end else begin
            rsp_valid <= rd_done;
            if (rd_done) begin
                rsp_raw <= mem_dq_i;
                rsp_tag <= tag_q;
            end
        end
    end

    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n == '1 && mem_oe_n && mem_we_n == '1 && !mem_dq_oe)); // R1

    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n == '1)); // R4

    AST_DQ_ONLY_UNDER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_we_n != '1 && mem_oe_n)); // R4

    AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ((~mem_we_n) & mem_cs_n) == '0); // R3

    AST_WE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_n != '1 && $past(mem_we_n) == '1) |-> ($past(mem_cs_n) == mem_cs_n)); // R3

    AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_n != '1 && $past(mem_we_n) != '1) |-> ($stable(mem_addr) && $stable(mem_dq_o))); // R3

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_oe_n)); // R2

    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs_n != '1 && mem_oe_n && $past(mem_cs_n) == '1) |-> $past(mem_oe_n, 2)); // R5

endmodule

// File: rtl/sram_ctl.sv
// Asynchronous static RAM controller top: derives cycle counts from
// nanosecond limits and the clock period, steers requests onto byte lanes
// for the width mode, and sequences the RAM control lines.
// Assumes a 32-bit RAM of four byte lanes; the data pad is external.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int WADDR_W = 19,
    parameter int CLK_NS  = 10,
    parameter int T_RC_NS = 20,
    parameter int T_AA_NS = 20,
    parameter int T_OE_NS = 10,
    parameter int T_WC_NS = 20,
    parameter int T_WP_NS = 15,
    parameter int T_CW_NS = 15,
    parameter int T_AW_NS = 15,
    parameter int T_AS_NS = 2,
    parameter int T_DW_NS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_wmode,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [WADDR_W+1:0]  req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [LANES-1:0]    req_mask,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [WADDR_W-1:0]  mem_addr,
    output logic [LANES-1:0]    mem_cs_n,
    output logic                mem_oe_n,
    output logic [LANES-1:0]    mem_we_n,
    output logic [DATA_W-1:0]   mem_dq_o,
    output logic                mem_dq_oe,
    input  logic [DATA_W-1:0]   mem_dq_i
);

    localparam int RD_CYC = imax(imax(ns_to_cyc(T_RC_NS, CLK_NS),
                                      ns_to_cyc(T_AA_NS, CLK_NS)),
                                 ns_to_cyc(T_OE_NS, CLK_NS));
    localparam int AS_CYC = ns_to_cyc(T_AS_NS, CLK_NS);
    localparam int WP_CYC = imax(imax(imax(ns_to_cyc(T_WP_NS, CLK_NS),
                                           ns_to_cyc(T_DW_NS, CLK_NS)),
                                      ns_to_cyc(T_WC_NS, CLK_NS) - AS_CYC),
                                 imax(ns_to_cyc(T_CW_NS, CLK_NS) - AS_CYC,
                                      ns_to_cyc(T_AW_NS, CLK_NS) - AS_CYC));

    logic [WADDR_W-1:0] map_addr;
    logic [LANES-1:0]   map_lanes;
    logic [DATA_W-1:0]  map_wdata;
    logic [TAG_W-1:0]   map_tag;
    logic [DATA_W-1:0]  rsp_raw;
    logic [TAG_W-1:0]   rsp_tag;

    assign map_tag = {cfg_wmode, req_addr[1:0]};

    sram_ctl_lanes #(
        .WADDR_W (WADDR_W)
    ) lanes_i (
        .mode       (cfg_wmode),
        .addr       (req_addr),
        .write      (req_write),
        .wdata      (req_wdata),
        .mask       (req_mask),
        .word_addr  (map_addr),
        .lanes      (map_lanes),
        .lane_wdata (map_wdata)
    );

    sram_ctl_seq #(
        .WADDR_W (WADDR_W),
        .RD_CYC  (RD_CYC),
        .AS_CYC  (AS_CYC),
        .WP_CYC  (WP_CYC)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .map_addr  (map_addr),
        .map_lanes (map_lanes),
        .map_wdata (map_wdata),
        .map_tag   (map_tag),
        .rsp_valid (rsp_valid),
        .rsp_raw   (rsp_raw),
        .rsp_tag   (rsp_tag),
        .mem_addr  (mem_addr),
        .mem_cs_n  (mem_cs_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .mem_dq_i  (mem_dq_i)
    );

    sram_ctl_rdext rdext_i (
        .mode  (rsp_tag[3:2]),
        .lo    (rsp_tag[1:0]),
        .raw   (rsp_raw),
        .rdata (rsp_rdata)
    );

endmodule

// File: tb/sram_ctl_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected addresses, lanes and read
// data; a monitor checks RAM-side pulse lengths and pops read responses.
module sram_ctl_tb_top;

    localparam int CLK_NS = 4;
    localparam int RD_EXP = 5;   // max(ceil 20/4, ceil 20/4, ceil 10/4)
    localparam int WP_EXP = 4;   // max(ceil 15/4, ceil 12/4, 5-1, 4-1, 4-1)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_wmode = 2'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [20:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_mask = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [18:0] mem_addr;
    logic [3:0]  mem_cs_n;
    logic        mem_oe_n;
    logic [3:0]  mem_we_n;
    logic [31:0] mem_dq_o;
    logic        mem_dq_oe;
    logic [31:0] mem_dq_i;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sram_ctl #(.CLK_NS(CLK_NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wmode(cfg_wmode),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i)
    );

    // RAM model (256 words) and bench reference bytes
    logic [31:0] mmem [0:255];
    logic [7:0]  refb [0:1023];
    int          rd_act = 0;

    initial begin
        for (int i = 0; i < 256; i++) mmem[i] = '0;
        for (int i = 0; i < 1024; i++) refb[i] = '0;
    end

    always @(posedge clk) begin
        rd_act <= (!mem_oe_n && mem_cs_n != 4'hF) ? rd_act + 1 : 0;
        for (int i = 0; i < 4; i++)
            if (!mem_cs_n[i] && !mem_we_n[i] && mem_dq_oe)
                mmem[mem_addr[7:0]][i*8 +: 8] <= mem_dq_o[i*8 +: 8];
    end

    always_comb begin
        for (int i = 0; i < 4; i++)
            mem_dq_i[i*8 +: 8] = (!mem_oe_n && !mem_cs_n[i] && mem_we_n[i] && rd_act >= RD_EXP - 1)
                                 ? mmem[mem_addr[7:0]][i*8 +: 8] : 8'hEE;
    end

    logic [31:0] exp_rd_q[$];
    string       rd_tag_q[$];
    logic [18:0] exp_a_q[$];
    logic [3:0]  exp_l_q[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [18:0] word_of(input logic [1:0] m, input logic [20:0] a);
        case (m)
            2'd1:    return a[19:1];
            2'd2:    return a[20:2];
            default: return a[18:0];
        endcase
    endfunction

    function automatic logic [3:0] lanes_of(input logic [1:0] m, input logic w,
                                            input logic [20:0] a, input logic [3:0] k);
        logic [3:0] sel;
        case (m)
            2'd1:    sel = a[0] ? 4'b1100 : 4'b0011;
            2'd2:    sel = 4'b0001 << a[1:0];
            default: sel = 4'b1111;
        endcase
        if (!w) return sel;
        case (m)
            2'd1:    return sel & {k[1:0], k[1:0]};
            2'd2:    return k[0] ? sel : 4'b0000;
            default: return k;
        endcase
    endfunction

    // Issue one request; update reference and queue expectations
    task automatic issue(input string tag, input logic [1:0] m, input logic w,
                         input logic [20:0] a, input logic [31:0] d, input logic [3:0] k);
        logic [18:0] wd;
        logic [3:0]  ln;
        logic [31:0] word;
        int          base;
        wd = word_of(m, a);
        ln = lanes_of(m, w, a, k);
        base = int'(wd[7:0]) * 4;
        if (w) begin
            for (int i = 0; i < 4; i++)
                if (ln[i])
                    refb[base + i] = (m == 2'd1) ? d[(i % 2)*8 +: 8] :
                                     (m == 2'd2) ? d[7:0] : d[i*8 +: 8];
        end else begin
            for (int i = 0; i < 4; i++) word[i*8 +: 8] = refb[base + i];
            case (m)
                2'd1:    exp_rd_q.push_back(a[0] ? {16'h0, word[31:16]} : {16'h0, word[15:0]});
                2'd2:    exp_rd_q.push_back({24'h0, word[a[1:0]*8 +: 8]});
                default: exp_rd_q.push_back(word);
            endcase
            rd_tag_q.push_back(tag);
        end
        @(negedge clk);
        cfg_wmode = m; req_valid = 1'b1; req_write = w;
        req_addr = a; req_wdata = d; req_mask = k;
        while (!req_ready) @(negedge clk);
        if (ln != 4'b0000) begin
            exp_a_q.push_back(wd);
            exp_l_q.push_back(ln);
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R9 ready low during access"}, {31'h0, req_ready}, 32'h0);
    endtask

    // Monitor: pulse lengths, addresses, lanes, turnaround and responses
    int         oe_run = 0, we_run = 0, dq_run = 0, gap = 10;
    logic [3:0] prev_cs_n = 4'hF;
    logic       prev_we_lo = 1'b0;
    logic       last_rd = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_cs_n != 4'hF && prev_cs_n == 4'hF) begin
                if (exp_a_q.size() == 0) begin
                    chk("R6 unexpected access", 32'h1, 32'h0);
                end else begin
                    chk("R6/R7/R8 word address", {13'h0, mem_addr}, {13'h0, exp_a_q.pop_front()});
                    chk("R6/R7/R8 lane selects", {28'h0, mem_cs_n}, {28'h0, ~exp_l_q.pop_front()});
                end
                if (mem_oe_n && last_rd)
                    chk("R5 read-to-write idle cycles >= 2", {31'h0, gap >= 2}, 32'h1);
                last_rd = !mem_oe_n;
            end
            gap = (mem_cs_n != 4'hF) ? 0 : gap + 1;

            if (!mem_oe_n) oe_run++;
            else if (oe_run > 0) begin
                chk("R2 read length", oe_run, RD_EXP);
                oe_run = 0;
            end

            if (mem_dq_oe) dq_run++;
            if (mem_we_n != 4'hF) begin
                if (!prev_we_lo)
                    chk("R3 setup cycle before strobe", {28'h0, prev_cs_n}, {28'h0, mem_cs_n});
                we_run++;
                prev_we_lo = 1'b1;
            end else begin
                if (we_run > 0) begin
                    chk("R3 strobe length", we_run, WP_EXP);
                    chk("R4 bus driven only under strobe", dq_run, we_run);
                    chk("R4 output enable high in write", {31'h0, mem_oe_n}, 32'h1);
                end
                we_run = 0;
                dq_run = 0;
                prev_we_lo = 1'b0;
            end
            prev_cs_n = mem_cs_n;

            if (rsp_valid) begin
                if (exp_rd_q.size() == 0) chk("R2 unexpected response", 32'h1, 32'h0);
                else chk({rd_tag_q.pop_front(), " read data"}, rsp_rdata, exp_rd_q.pop_front());
            end
        end
    end

    // Response pulse width check
    logic rsp_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && rsp_valid && rsp_prev)
            chk("R2 response one cycle", 32'h1, 32'h0);
        rsp_prev = rsp_valid;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset selects", {28'h0, mem_cs_n}, 32'hF);
        chk("R1 reset strobes", {28'h0, mem_we_n}, 32'hF);
        chk("R1 reset oe/dq_oe", {30'h0, mem_oe_n, mem_dq_oe}, 32'h2);
        chk("R1 reset ready", {31'h0, req_ready}, 32'h1);
        chk("R1 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);

        // R6: 32-bit full and masked writes, read-to-write turnaround (R5)
        issue("R6 wr full", 2'd0, 1'b1, 21'd5, 32'h1122_3344, 4'hF);
        issue("R6 rd full", 2'd0, 1'b0, 21'd5, 32'h0, 4'h0);
        issue("R5 wr after rd", 2'd0, 1'b1, 21'd5, 32'hAABB_CCDD, 4'b0101);
        issue("R6 rd masked", 2'd0, 1'b0, 21'd5, 32'h0, 4'h0);
        issue("R6 rd again", 2'd0, 1'b0, 21'd5, 32'h0, 4'h0);

        // R7: 16-bit halves, partial half mask, cross-width read
        issue("R7 wr lo half", 2'd1, 1'b1, 21'd20, 32'h5555_BEEF, 4'h3);
        issue("R7 wr hi half", 2'd1, 1'b1, 21'd21, 32'h6666_CAFE, 4'h3);
        issue("R7 rd hi half", 2'd1, 1'b0, 21'd21, 32'h0, 4'h0);
        issue("R7 rd lo half", 2'd1, 1'b0, 21'd20, 32'h0, 4'h0);
        issue("R7 wr lo byte of half", 2'd1, 1'b1, 21'd20, 32'h7777_1234, 4'b0001);
        issue("R7 rd 32 view", 2'd0, 1'b0, 21'd10, 32'h0, 4'h0);

        // R8: byte lanes, ignored write with mask bit 0 clear
        issue("R8 wr b0", 2'd2, 1'b1, 21'd120, 32'hFFFF_FF01, 4'h1);
        issue("R8 wr b1", 2'd2, 1'b1, 21'd121, 32'hFFFF_FF02, 4'h1);
        issue("R8 wr b2", 2'd2, 1'b1, 21'd122, 32'hFFFF_FF03, 4'h1);
        issue("R8 wr b3", 2'd2, 1'b1, 21'd123, 32'hFFFF_FF04, 4'h1);
        issue("R8 rd 32 view", 2'd0, 1'b0, 21'd30, 32'h0, 4'h0);
        issue("R8 rd byte2", 2'd2, 1'b0, 21'd122, 32'h0, 4'h0);
        issue("R8 masked-off wr", 2'd2, 1'b1, 21'd122, 32'h0000_0099, 4'hE);
        issue("R8 rd after masked-off", 2'd2, 1'b0, 21'd122, 32'h0, 4'h0);

        // R6: mode 3 behaves as 32-bit
        issue("R6 mode3 wr", 2'd3, 1'b1, 21'd7, 32'hDEAD_0F0F, 4'hF);
        issue("R6 mode3 rd", 2'd3, 1'b0, 21'd7, 32'h0, 4'h0);

        for (int n = 0; n < 200 && exp_rd_q.size() != 0; n++) @(negedge clk);
        repeat (5) @(negedge clk);
        chk("R2 all responses returned", exp_rd_q.size(), 0);
        // R1: standby when idle
        chk("R1 idle selects", {28'h0, mem_cs_n}, 32'hF);
        chk("R1 idle oe/dq_oe", {30'h0, mem_oe_n, mem_dq_oe}, 32'h2);
        chk("R1 idle ready", {31'h0, req_ready}, 32'h1);
        finish_run();
    end

endmodule